// File: doc/BRIEF.md
# Atomic Test-and-Set Shared Byte Memory

This block is a byte-wide shared store for several CPU requesters and one channel port. A CPU can read a byte, write a byte, or run an atomic test-and-set on a byte. The test-and-set reads the addressed byte and returns a condition code taken from its most significant bit. It then stores 8'hFF into the byte. No other CPU can reach the store between that read and that write.

CPU requests are accepted one per cycle through a round-robin arbiter. Every accepted access enters a one-stage execution register and commits on the next edge. Each CPU has a counter of its own accepted-but-uncommitted accesses. A test-and-set is not accepted until that CPU's counter is zero. While a test-and-set is in flight, a lock flag keeps all CPU grants closed. The channel port has its own read/write path. The lock does not block it, so it can act on the same byte while a test-and-set is under way.

An address at or above the memory depth is a fault for every access type. A faulted access writes nothing, returns data 0 and condition code 0, and raises a fault flag.

Top module: `tas_mem_unit`

## Requirements
- R1: After reset all bytes read as 8'h00, and no grant, done or channel read-valid is asserted.
- R2: A test-and-set returns the old byte and a condition code of 0 when its bit 7 was 0, or 1 when its bit 7 was 1. Only bit 7 is tested, and bit 1 of the condition code is never set.
- R3: After a test-and-set commits, the addressed byte reads back as 8'hFF, whatever it held before.
- R4: The write data presented with a test-and-set has no effect on the stored byte.
- R5: A test-and-set is not granted while the same CPU still has an accepted access that has not committed.
- R6: A CPU's done pulse is high for exactly one cycle. It comes two clock edges after its grant, which is one cycle after its access commits.
- R7: At most one CPU is granted per cycle. No CPU is granted in the cycle after a test-and-set grant.
- R8: When every CPU requests, grants rotate in increasing index order with wraparound, one CPU per cycle.
- R9: When two CPUs race a test-and-set on a byte that holds 8'h00, exactly one of them receives condition code 0 and the other receives 1.
- R10: Channel reads and writes are accepted while a test-and-set is in flight. Channel read data is returned one cycle after the request.
- R11: A CPU or channel address at or above DEPTH sets the fault flag, returns data 0 and condition code 0, and changes no byte.
- R12: A CPU write (op 2'b01) stores its data, and a later CPU read (op 2'b00) of that address returns it. Op 2'b10 is test-and-set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | NUM_CPU | Per-CPU request, held until granted |
| cpu_op | input | NUM_CPU x 2 | Per-CPU op: 00 read, 01 write, 10 test-and-set |
| cpu_addr | input | NUM_CPU x ADDR_W | Per-CPU byte address |
| cpu_wdata | input | NUM_CPU x 8 | Per-CPU write data |
| cpu_gnt | output | NUM_CPU | Request accepted this cycle |
| cpu_done | output | NUM_CPU | One-cycle completion pulse |
| cpu_rsp_data | output | 8 | Old byte for read and test-and-set of the completing CPU |
| cpu_rsp_cc | output | 2 | Condition code of the completing test-and-set |
| cpu_rsp_fault | output | 1 | Address fault of the completing access |
| ch_req | input | 1 | Channel access strobe |
| ch_we | input | 1 | Channel write enable |
| ch_addr | input | ADDR_W | Channel byte address |
| ch_wdata | input | 8 | Channel write data |
| ch_rvalid | output | 1 | Channel read data valid |
| ch_rdata | output | 8 | Channel read data |
| ch_fault | output | 1 | Channel address fault |

## Verification
The bench builds the unit with NUM_CPU = 3, so the round-robin pointer has to wrap at a count that is not a power of two, and a three-way contention shows the full rotation. DEPTH stays at 48 with a 6-bit address. This leaves addresses 48 to 63 free to drive the fault path from both the CPU and channel sides. With these values the tests also cover a test-and-set racing another, a test-and-set waiting behind its own earlier read, and a channel write that lands while the lock holds off a second CPU.

// File: rtl/tasu_pkg.sv
// Shared definitions for the test-and-set memory unit.
// Assumes: op codes are fixed by the port contract.
package tasu_pkg;
    typedef enum logic [1:0] {
        OP_RD  = 2'b00,
        OP_WR  = 2'b01,
        OP_TAS = 2'b10,
        OP_RSV = 2'b11
    } op_e;

    localparam logic [7:0] ALL_ONES = 8'hFF;
endpackage

// File: rtl/tasu_rr_arb.sv
// Round-robin arbiter: grants at most one requester per cycle, searching from
// the index after the last winner. Assumes: hold closes all grants.
module tasu_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         hold,
    output logic [N-1:0] gnt
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [IDX_W-1:0] last;
    logic [IDX_W-1:0] win;

    // pick the first eligible requester after the previous winner
    always_comb begin
        gnt = '0;
        win = last;
        for (int k = 1; k <= N; k++) begin
            int idx;
            idx = (int'(last) + k) % N;
            if (gnt == '0 && req[IDX_W'(idx)] && !hold) begin
                gnt[IDX_W'(idx)] = 1'b1;
                win = IDX_W'(idx);
            end
        end
    end

    // remember the winner so that it is searched last next time
    always_ff @(posedge clk) begin
        if (!rst_n)
            last <= IDX_W'(N - 1);
        else if (gnt != '0)
            last <= win;
    end
endmodule

// File: rtl/tasu_pend.sv
// Per-CPU count of accepted but uncommitted accesses.
// Assumes: the counter never exceeds 2**W-1 (one execution stage).
module tasu_pend #(
    parameter int N = 4,
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] inc,
    input  logic [N-1:0] dec,
    output logic [N-1:0] zero
);
    for (genvar i = 0; i < N; i++) begin : g_cnt
        logic [W-1:0] cnt;

        // add on grant, subtract on commit
        always_ff @(posedge clk) begin
            if (!rst_n)
                cnt <= '0;
            else if (inc[i] && !dec[i])
                cnt <= cnt + 1'b1;
            else if (dec[i] && !inc[i])
                cnt <= cnt - 1'b1;
        end

        assign zero[i] = (cnt == '0);
    end
endmodule

// File: rtl/tasu_core.sv
// Storage and execution: one execution register, commit on the next edge,
// response one cycle after commit. The test-and-set reads and writes in the
// same commit edge. The channel port bypasses the lock and wins a same-byte
// collision. Assumes: a new issue never arrives while lock is high.
module tasu_core
    import tasu_pkg::*;
#(
    parameter int N      = 4,
    parameter int ADDR_W = 6,
    parameter int DEPTH  = 48
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        iss_valid,
    input  logic [((N>1)?$clog2(N):1)-1:0] iss_cpu,
    input  logic [1:0]                  iss_op,
    input  logic [ADDR_W-1:0]           iss_addr,
    input  logic [7:0]                  iss_wdata,
    output logic                        lock,
    output logic [N-1:0]                commit,
    output logic [N-1:0]                done,
    output logic [7:0]                  rsp_data,
    output logic [1:0]                  rsp_cc,
    output logic                        rsp_fault,
    input  logic                        ch_req,
    input  logic                        ch_we,
    input  logic [ADDR_W-1:0]           ch_addr,
    input  logic [7:0]                  ch_wdata,
    output logic                        ch_rvalid,
    output logic [7:0]                  ch_rdata,
    output logic                        ch_fault
);
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);

    logic [7:0]        mem [0:DEPTH-1];
    logic              s1_valid, s1_fault;
    logic [IDX_W-1:0]  s1_cpu;
    op_e               s1_op;
    logic [ADDR_W-1:0] s1_addr;
    logic [7:0]        s1_wdata;
    logic [7:0]        old_byte;
    logic              ch_bad;

    assign ch_bad   = ({1'b0, ch_addr} >= LIMIT);
    assign old_byte = s1_fault ? 8'h00 : mem[s1_addr];

    // capture the granted access into the execution register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_fault <= 1'b0;
            s1_cpu   <= '0;
            s1_op    <= OP_RD;
            s1_addr  <= '0;
            s1_wdata <= '0;
        end else begin
            s1_valid <= iss_valid;
            s1_fault <= ({1'b0, iss_addr} >= LIMIT);
            s1_cpu   <= iss_cpu;
            s1_op    <= op_e'(iss_op);
            s1_addr  <= iss_addr;
            s1_wdata <= iss_wdata;
        end
    end

    // lock spans from a test-and-set grant to its commit edge
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock <= 1'b0;
        else if (iss_valid && op_e'(iss_op) == OP_TAS)
            lock <= 1'b1;
        else if (s1_valid && s1_op == OP_TAS)
            lock <= 1'b0;
    end

    // one-hot commit strobe of the executing CPU
    always_comb begin
        commit = '0;
        if (s1_valid)
            commit[s1_cpu] = 1'b1;
    end

    // byte array: CPU commit first, channel write takes a same-byte collision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++)
                mem[a] <= 8'h00;
        end else begin
            if (s1_valid && !s1_fault && s1_op == OP_WR)
                mem[s1_addr] <= s1_wdata;
            else if (s1_valid && !s1_fault && s1_op == OP_TAS)
                mem[s1_addr] <= ALL_ONES;
            if (ch_req && ch_we && !ch_bad)
                mem[ch_addr] <= ch_wdata;
        end
    end

    // CPU response one cycle after commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= '0;
            rsp_data  <= '0;
            rsp_cc    <= '0;
            rsp_fault <= 1'b0;
        end else begin
            done      <= commit;
            rsp_fault <= s1_valid && s1_fault;
            rsp_data  <= (s1_op == OP_WR) ? 8'h00 : old_byte;
            rsp_cc    <= (s1_op == OP_TAS && !s1_fault) ? {1'b0, old_byte[7]} : 2'b00;
        end
    end

    // channel response one cycle after its request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_rvalid <= 1'b0;
            ch_rdata  <= '0;
            ch_fault  <= 1'b0;
        end else begin
            ch_rvalid <= ch_req && !ch_we;
            ch_rdata  <= (ch_req && !ch_bad) ? mem[ch_addr] : 8'h00;
            ch_fault  <= ch_req && ch_bad;
        end
    end
endmodule

// File: rtl/tas_mem_unit.sv
// Top level: arbitration with drain gating, pending tracking, and storage.
// Assumes: each CPU holds its request and fields stable until granted.
module tas_mem_unit
    import tasu_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 6,
    parameter int DEPTH   = 48,
    parameter int PEND_W  = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NUM_CPU-1:0]               cpu_req,
    input  logic [NUM_CPU-1:0][1:0]          cpu_op,
    input  logic [NUM_CPU-1:0][ADDR_W-1:0]   cpu_addr,
    input  logic [NUM_CPU-1:0][7:0]          cpu_wdata,
    output logic [NUM_CPU-1:0]               cpu_gnt,
    output logic [NUM_CPU-1:0]               cpu_done,
    output logic [7:0]                       cpu_rsp_data,
    output logic [1:0]                       cpu_rsp_cc,
    output logic                             cpu_rsp_fault,
    input  logic                             ch_req,
    input  logic                             ch_we,
    input  logic [ADDR_W-1:0]                ch_addr,
    input  logic [7:0]                       ch_wdata,
    output logic                             ch_rvalid,
    output logic [7:0]                       ch_rdata,
    output logic                             ch_fault
);
    localparam int IDX_W = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;

    logic [NUM_CPU-1:0] eligible, pend_zero, commit;
    logic               lock;
    logic [IDX_W-1:0]   iss_cpu;
    logic [1:0]         iss_op;
    logic [ADDR_W-1:0]  iss_addr;
    logic [7:0]         iss_wdata;

    // a test-and-set waits until its own earlier accesses have committed
    always_comb begin
        for (int i = 0; i < NUM_CPU; i++)
            eligible[i] = cpu_req[i] && (op_e'(cpu_op[i]) != OP_TAS || pend_zero[i]);
    end

    // route the granted CPU's fields to the execution stage
    always_comb begin
        iss_cpu   = '0;
        iss_op    = '0;
        iss_addr  = '0;
        iss_wdata = '0;
        for (int i = 0; i < NUM_CPU; i++) begin
            if (cpu_gnt[i]) begin
                iss_cpu   = IDX_W'(i);
                iss_op    = cpu_op[i];
                iss_addr  = cpu_addr[i];
                iss_wdata = cpu_wdata[i];
            end
        end
    end

    tasu_rr_arb #(.N(NUM_CPU)) u_arb (
        .clk  (clk),
        .rst_n(rst_n),
        .req  (eligible),
        .hold (lock),
        .gnt  (cpu_gnt)
    );

    tasu_pend #(.N(NUM_CPU), .W(PEND_W)) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (cpu_gnt),
        .dec  (commit),
        .zero (pend_zero)
    );

    tasu_core #(.N(NUM_CPU), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .iss_valid(|cpu_gnt),
        .iss_cpu  (iss_cpu),
        .iss_op   (iss_op),
        .iss_addr (iss_addr),
        .iss_wdata(iss_wdata),
        .lock     (lock),
        .commit   (commit),
        .done     (cpu_done),
        .rsp_data (cpu_rsp_data),
        .rsp_cc   (cpu_rsp_cc),
        .rsp_fault(cpu_rsp_fault),
        .ch_req   (ch_req),
        .ch_we    (ch_we),
        .ch_addr  (ch_addr),
        .ch_wdata (ch_wdata),
        .ch_rvalid(ch_rvalid),
        .ch_rdata (ch_rdata),
        .ch_fault (ch_fault)
    );
endmodule

// File: rtl/tasu_chk.sv
// Protocol checker for tas_mem_unit, attached with bind.
// Assumes: only port-level signals of the unit are observed.
module tasu_chk #(
    parameter int NUM_CPU = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_CPU-1:0][1:0] cpu_op,
    input logic [NUM_CPU-1:0]      cpu_gnt,
    input logic [NUM_CPU-1:0]      cpu_done,
    input logic [1:0]              cpu_rsp_cc,
    input logic                    cpu_rsp_fault
);
    logic [NUM_CPU-1:0] tas_vec;

    // flag CPUs presenting a test-and-set
    always_comb begin
        for (int i = 0; i < NUM_CPU; i++)
            tas_vec[i] = (cpu_op[i] == 2'b10);
    end

    // R7
    gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cpu_gnt));

    // R7
    lock_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_gnt & tas_vec) != '0) |=> (cpu_gnt == '0));

    // R6
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_gnt != '0) |=> ##1 $onehot(cpu_done));

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cpu_done));

    // R2
    cc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done != '0) |-> !cpu_rsp_cc[1]);

    // R11
    fault_cc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cpu_done != '0) && cpu_rsp_fault) |-> (cpu_rsp_cc == 2'b00));
endmodule

bind tas_mem_unit tasu_chk #(.NUM_CPU(NUM_CPU)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_op       (cpu_op),
    .cpu_gnt      (cpu_gnt),
    .cpu_done     (cpu_done),
    .cpu_rsp_cc   (cpu_rsp_cc),
    .cpu_rsp_fault(cpu_rsp_fault)
);

// File: tb/tas_mem_unit_bench.sv
module tas_mem_unit_bench;
    localparam int N  = 3;
    localparam int AW = 6;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [N-1:0]          req = '0;
    logic [N-1:0][1:0]     op = '0;
    logic [N-1:0][AW-1:0]  addr = '0;
    logic [N-1:0][7:0]     wd = '0;
    logic [N-1:0]          gnt, done;
    logic [7:0]            rsp_data;
    logic [1:0]            rsp_cc;
    logic                  rsp_fault;
    logic                  ch_req = 1'b0, ch_we = 1'b0;
    logic [AW-1:0]         ch_addr = '0;
    logic [7:0]            ch_wdata = '0;
    logic                  ch_rvalid, ch_fault;
    logic [7:0]            ch_rdata;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    tas_mem_unit #(.NUM_CPU(N), .ADDR_W(AW), .DEPTH(48), .PEND_W(2)) u_tas_mem_unit (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(req), .cpu_op(op), .cpu_addr(addr), .cpu_wdata(wd),
        .cpu_gnt(gnt), .cpu_done(done),
        .cpu_rsp_data(rsp_data), .cpu_rsp_cc(rsp_cc), .cpu_rsp_fault(rsp_fault),
        .ch_req(ch_req), .ch_we(ch_we), .ch_addr(ch_addr), .ch_wdata(ch_wdata),
        .ch_rvalid(ch_rvalid), .ch_rdata(ch_rdata), .ch_fault(ch_fault)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one CPU access, with the grant-to-done timing checked (R6)
    task automatic cpu_do(input int id, input logic [1:0] o, input logic [AW-1:0] a,
                          input logic [7:0] d, output logic [7:0] rd,
                          output logic [1:0] cc, output logic f);
        int wait_cyc = 0;
        @(negedge clk);
        req[id] = 1'b1; op[id] = o; addr[id] = a; wd[id] = d;
        #1;
        while (!gnt[id] && wait_cyc < 20) begin
            @(negedge clk); #1; wait_cyc++;
        end
        @(posedge clk); #1 req[id] = 1'b0;
        @(negedge clk);
        chk("R6 done not early", {31'b0, done[id]}, 32'd0);
        @(negedge clk);
        chk("R6 done after commit", {29'b0, done}, 32'(1 << id));
        rd = rsp_data; cc = rsp_cc; f = rsp_fault;
        @(negedge clk);
        chk("R6 done one cycle", {31'b0, done[id]}, 32'd0);
    endtask

    task automatic ch_do(input logic we, input logic [AW-1:0] a, input logic [7:0] d,
                         output logic [7:0] rd, output logic f);
        @(negedge clk);
        ch_req = 1'b1; ch_we = we; ch_addr = a; ch_wdata = d;
        @(posedge clk); #1 ch_req = 1'b0; ch_we = 1'b0;
        @(negedge clk);
        if (!we) chk("R10 channel read valid", {31'b0, ch_rvalid}, 32'd1);
        rd = ch_rdata; f = ch_fault;
    endtask

    task automatic t_reset;
        logic [7:0] rd; logic [1:0] cc; logic f;
        chk("R1 gnt idle", {29'b0, gnt}, 0);
        chk("R1 done idle", {29'b0, done}, 0);
        chk("R1 ch_rvalid idle", {31'b0, ch_rvalid}, 0);
        cpu_do(0, 2'b00, 6'd7, 8'h00, rd, cc, f);
        chk("R1 byte cleared", {24'b0, rd}, 0);
    endtask

    task automatic t_rdwr;
        logic [7:0] rd; logic [1:0] cc; logic f;
        cpu_do(1, 2'b01, 6'd3, 8'h12, rd, cc, f);
        cpu_do(2, 2'b00, 6'd3, 8'h00, rd, cc, f);
        chk("R12 read after write", {24'b0, rd}, 32'h12);
    endtask

    task automatic t_tas_basic;
        logic [7:0] rd; logic [1:0] cc; logic f;
        cpu_do(0, 2'b10, 6'd3, 8'h00, rd, cc, f);
        chk("R2 cc for bit7 zero", {30'b0, cc}, 0);
        chk("R2 old byte returned", {24'b0, rd}, 32'h12);
        cpu_do(2, 2'b00, 6'd3, 8'h00, rd, cc, f);
        chk("R3 R4 byte all ones despite wdata 00", {24'b0, rd}, 32'hFF);
        cpu_do(1, 2'b10, 6'd3, 8'h00, rd, cc, f);
        chk("R2 cc for bit7 one", {30'b0, cc}, 1);
        cpu_do(1, 2'b01, 6'd4, 8'h7F, rd, cc, f);
        cpu_do(0, 2'b10, 6'd4, 8'h3C, rd, cc, f);
        chk("R2 only bit7 tested 7F", {30'b0, cc}, 0);
        cpu_do(2, 2'b00, 6'd4, 8'h00, rd, cc, f);
        chk("R3 R4 7F becomes FF", {24'b0, rd}, 32'hFF);
        cpu_do(1, 2'b01, 6'd6, 8'h80, rd, cc, f);
        cpu_do(2, 2'b10, 6'd6, 8'h00, rd, cc, f);
        chk("R2 only bit7 tested 80", {30'b0, cc}, 1);
    endtask

    task automatic t_drain;
        logic [7:0] rd; logic f;
        ch_do(1'b1, 6'd5, 8'h81, rd, f);
        @(negedge clk);
        req[0] = 1'b1; op[0] = 2'b00; addr[0] = 6'd5; wd[0] = 8'h00;
        #1 chk("R5 read granted", {31'b0, gnt[0]}, 1);
        @(posedge clk); #1 op[0] = 2'b10;
        @(negedge clk); #1 chk("R5 tas held while read pending", {31'b0, gnt[0]}, 0);
        @(negedge clk); #1 chk("R5 tas granted after drain", {31'b0, gnt[0]}, 1);
        @(posedge clk); #1 req[0] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R5 tas done", {31'b0, done[0]}, 1);
        chk("R2 tas cc after drain", {30'b0, rsp_cc}, 1);
    endtask

    task automatic t_rr;
        int g[3];
        for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            if (s == 0) begin
                for (int i = 0; i < N; i++) begin
                    req[i] = 1'b1; op[i] = 2'b00; addr[i] = AW'(i);
                end
            end
            #1 g[s] = -1;
            for (int i = 0; i < N; i++) if (gnt[i]) g[s] = i;
            @(posedge clk); #1 if (g[s] >= 0) req[g[s]] = 1'b0;
        end
        req = '0;
        chk("R8 rotation second", g[1], (g[0] + 1) % 3);
        chk("R8 rotation third", g[2], (g[0] + 2) % 3);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_race;
        int gc[2]; logic [1:0] cc[2]; int nd = 0;
        logic [7:0] rd; logic [1:0] c; logic f;
        gc[0] = -1; gc[1] = -1; cc[0] = 2'b11; cc[1] = 2'b11;
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            req[i] = 1'b1; op[i] = 2'b10; addr[i] = 6'd20; wd[i] = 8'h55;
        end
        for (int cyc = 0; cyc < 8; cyc++) begin
            logic [1:0] drop;
            #1 drop = '0;
            for (int i = 0; i < 2; i++) begin
                if (gnt[i]) begin gc[i] = cyc; drop[i] = 1'b1; end
                if (done[i]) begin cc[i] = rsp_cc; nd++; end
            end
            @(posedge clk); #1
            for (int i = 0; i < 2; i++) if (drop[i]) req[i] = 1'b0;
            @(negedge clk);
        end
        chk("R9 both completed", nd, 2);
        chk("R9 exactly one winner", ((cc[0] == 2'b00) ? 1 : 0) + ((cc[1] == 2'b00) ? 1 : 0), 1);
        chk("R9 loser sees one", {30'b0, cc[0] ^ cc[1]}, 1);
        chk("R7 grants apart", ((gc[0] - gc[1] >= 2) || (gc[1] - gc[0] >= 2)) ? 1 : 0, 1);
        cpu_do(2, 2'b00, 6'd20, 8'h00, rd, c, f);
        chk("R3 race byte FF", {24'b0, rd}, 32'hFF);
    endtask

    task automatic t_channel;
        logic [7:0] rd; logic f;
        @(negedge clk);
        req[0] = 1'b1; op[0] = 2'b10; addr[0] = 6'd10; wd[0] = 8'h00;
        #1 chk("R7 tas granted", {31'b0, gnt[0]}, 1);
        @(posedge clk); #1 req[0] = 1'b0;
        req[1] = 1'b1; op[1] = 2'b00; addr[1] = 6'd12;
        ch_req = 1'b1; ch_we = 1'b1; ch_addr = 6'd11; ch_wdata = 8'h3C;
        @(negedge clk); #1 chk("R7 other cpu stalled by lock", {31'b0, gnt[1]}, 0);
        @(posedge clk); #1 ch_req = 1'b0; ch_we = 1'b0;
        @(negedge clk); #1 chk("R7 other cpu after unlock", {31'b0, gnt[1]}, 1);
        @(posedge clk); #1 req[1] = 1'b0;
        repeat (2) @(negedge clk);
        ch_do(1'b0, 6'd11, 8'h00, rd, f);
        chk("R10 channel write during lock", {24'b0, rd}, 32'h3C);
        ch_do(1'b0, 6'd10, 8'h00, rd, f);
        chk("R10 channel sees tas byte", {24'b0, rd}, 32'hFF);
    endtask

    task automatic t_fault;
        logic [7:0] rd; logic [1:0] cc; logic f;
        cpu_do(0, 2'b10, 6'd50, 8'h00, rd, cc, f);
        chk("R11 tas fault flag", {31'b0, f}, 1);
        chk("R11 tas fault cc", {30'b0, cc}, 0);
        chk("R11 tas fault data", {24'b0, rd}, 0);
        cpu_do(1, 2'b01, 6'd48, 8'hAA, rd, cc, f);
        chk("R11 write fault flag", {31'b0, f}, 1);
        ch_do(1'b0, 6'd63, 8'h00, rd, f);
        chk("R11 channel fault", {31'b0, f}, 1);
        chk("R11 channel fault data", {24'b0, rd}, 0);
        cpu_do(2, 2'b00, 6'd47, 8'h00, rd, cc, f);
        chk("R11 last byte no fault", {31'b0, f}, 0);
        chk("R11 last byte untouched", {24'b0, rd}, 0);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset;
        t_rdwr;
        t_tas_basic;
        t_drain;
        t_rr;
        t_race;
        t_channel;
        t_fault;
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule